// File: doc/BRIEF.md
# Pixel and Control Output Demultiplexer

This block sits at the back end of a display-link receiver, after the stage that turns the serial stream into decoded words. A word-valid strobe marks each decoded word. A word holds an 18-bit pixel field, a 9-bit control field and a data-enable flag. The block holds each accepted word for one word period. It then steers the word into one of two registered output groups: pixel when data-enable is set, control when it is clear. The group that is not chosen keeps its last value.

The lock indicator is active low. Words are taken only while it reads low. An output-enable input drives the outputs or floats them, and the lock indicator is always driven. A select input picks which edge of the forwarded output clock sits in the middle of each data cycle, so that a downstream device can capture on that edge.

Top module: `vid_ctl_demux`

## Requirements
- R1: While reset is applied and after it is released, pixel and control outputs read zero, data-enable reads 0 and the lock indicator reads 1.
- R2: A word whose data-enable bit is 1, when presented, loads its pixel field into the pixel output and sets data-enable out to 1. The control output keeps its previous value.
- R3: A word whose data-enable bit is 0, when presented, loads its control field into the control output and sets data-enable out to 0. The pixel output keeps its previous value.
- R4: Outputs run one word behind the input. A word accepted on a strobe is presented at the clock edge of the next accepted strobe. The first strobe after lock is gained only primes the pipeline and leaves the outputs unchanged.
- R5: While the lock indicator reads 1, strobes are ignored and all outputs hold. Any primed word is discarded. A strobe at the edge where the lock indicator changes from 0 to 1 is still accepted.
- R6: The lock indicator is the inverse of the link-locked input, registered, and it changes on the clock edge after that input changes.
- R7: With out_en at 0, the pixel, control, data-enable and output-clock pins are high-impedance while the lock indicator stays driven. Words keep flowing internally, and their values appear once out_en returns to 1.
- R8: With edge_rise at 1, the output clock is the inverse of clk, so its rising edge falls mid-cycle. With edge_rise at 0, it follows clk, so its falling edge falls mid-cycle.
- R9: Cycles without word_vld change no output, whatever the word inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | Decoded-word strobe |
| word_pix | input | 18 | Pixel field of the word |
| word_ctl | input | 9 | Control field of the word |
| word_de | input | 1 | Data-enable flag of the word |
| link_ok | input | 1 | Link-locked status from clock recovery |
| edge_rise | input | 1 | 1: rising capture edge, 0: falling |
| out_en | input | 1 | 1 drives the outputs, 0 floats them |
| pix_out | output | 18 | Pixel output group |
| ctl_out | output | 9 | Control output group |
| de_out | output | 1 | Data-enable output |
| pclk_out | output | 1 | Forwarded output clock |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
Loss of lock and a word strobe can fall in the same cycle. The bench provokes this by dropping link_ok at the same negative edge that raises word_vld. It then expects that word to be taken, because the indicator is still low at that edge. It also expects the primed word to be dropped once the indicator reads high. After relock, a reference model that tracks each group's last value confirms that the first new word only primes the pipeline.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
    localparam int PIX_W_DEF = 18;
    localparam int CTL_W_DEF = 9;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } cap_edge_e;
endpackage

// File: rtl/vcd_stage.sv
module vcd_stage #(
    parameter int PW = 18,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          vld,
    input  logic [PW-1:0] in_pix,
    input  logic [CW-1:0] in_ctl,
    input  logic          in_de,
    output logic [PW-1:0] st_pix,
    output logic [CW-1:0] st_ctl,
    output logic          st_de,
    output logic          fire
);
    typedef struct packed {
        logic          v;
        logic [PW-1:0] p;
        logic [CW-1:0] c;
        logic          d;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.v = 1'b0;
        end else if (vld) begin
            st_d.v = 1'b1;
            st_d.p = in_pix;
            st_d.c = in_ctl;
            st_d.d = in_de;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire   = vld && !hold && st_q.v;
    assign st_pix = st_q.p;
    assign st_ctl = st_q.c;
    assign st_de  = st_q.d;
endmodule

// File: rtl/vcd_steer.sv
module vcd_steer #(
    parameter int PW = 18,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [PW-1:0] st_pix,
    input  logic [CW-1:0] st_ctl,
    input  logic          st_de,
    output logic [PW-1:0] pix_q,
    output logic [CW-1:0] ctl_q,
    output logic          de_q
);
    typedef struct packed {
        logic [PW-1:0] p;
        logic [CW-1:0] c;
        logic          d;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (fire) begin
            g_d.d = st_de;
            if (st_de) g_d.p = st_pix;
            else       g_d.c = st_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign pix_q = g_q.p;
    assign ctl_q = g_q.c;
    assign de_q  = g_q.d;
endmodule

// File: rtl/vcd_drive.sv
module vcd_drive
    import vcd_pkg::*;
#(
    parameter int PW = 18,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          out_en,
    input  logic          edge_rise,
    input  logic [PW-1:0] pix_q,
    input  logic [CW-1:0] ctl_q,
    input  logic          de_q,
    output logic [PW-1:0] pix_out,
    output logic [CW-1:0] ctl_out,
    output logic          de_out,
    output logic          pclk_out
);
    cap_edge_e sel;
    logic      pclk_int;

    assign sel      = cap_edge_e'(edge_rise);
    assign pclk_int = (sel == EDGE_RISE) ? ~clk : clk;

    assign pix_out  = out_en ? pix_q    : {PW{1'bz}};
    assign ctl_out  = out_en ? ctl_q    : {CW{1'bz}};
    assign de_out   = out_en ? de_q     : 1'bz;
    assign pclk_out = out_en ? pclk_int : 1'bz;
endmodule

// File: rtl/vid_ctl_demux.sv
module vid_ctl_demux
    import vcd_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int CTL_W = CTL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic [PIX_W-1:0] word_pix,
    input  logic [CTL_W-1:0] word_ctl,
    input  logic             word_de,
    input  logic             link_ok,
    input  logic             edge_rise,
    input  logic             out_en,
    output logic [PIX_W-1:0] pix_out,
    output logic [CTL_W-1:0] ctl_out,
    output logic             de_out,
    output logic             pclk_out,
    output logic             lock_n
);
    logic             lock_n_d, lock_n_q;
    logic [PIX_W-1:0] st_pix, pix_q;
    logic [CTL_W-1:0] st_ctl, ctl_q;
    logic             st_de, de_q, fire;

    always_comb begin
        lock_n_d = ~link_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_n_q <= 1'b1;
        else        lock_n_q <= lock_n_d;
    end

    assign lock_n = lock_n_q;

    vcd_stage #(.PW(PIX_W), .CW(CTL_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .hold(lock_n_q), .vld(word_vld),
        .in_pix(word_pix), .in_ctl(word_ctl), .in_de(word_de),
        .st_pix(st_pix), .st_ctl(st_ctl), .st_de(st_de), .fire(fire)
    );

    vcd_steer #(.PW(PIX_W), .CW(CTL_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .st_pix(st_pix), .st_ctl(st_ctl), .st_de(st_de),
        .pix_q(pix_q), .ctl_q(ctl_q), .de_q(de_q)
    );

    vcd_drive #(.PW(PIX_W), .CW(CTL_W)) u_drive (
        .clk(clk), .out_en(out_en), .edge_rise(edge_rise),
        .pix_q(pix_q), .ctl_q(ctl_q), .de_q(de_q),
        .pix_out(pix_out), .ctl_out(ctl_out), .de_out(de_out),
        .pclk_out(pclk_out)
    );
endmodule

// File: rtl/vcd_chk.sv
module vcd_chk #(
    parameter int PW = 18,
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word_vld,
    input logic          link_ok,
    input logic          out_en,
    input logic          lock_n,
    input logic          lock_n_q,
    input logic [PW-1:0] pix_q,
    input logic [CW-1:0] ctl_q,
    input logic          de_q,
    input logic [PW-1:0] pix_out
);
    // R2
    pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pix_q) |-> (de_q && $stable(ctl_q)));

    // R3
    ctl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> (!de_q && $stable(pix_q)));

    // R5
    unlocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n_q |=> ($stable(pix_q) && $stable(ctl_q) && $stable(de_q)));

    // R6
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ok) |=> !lock_n);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(pix_q) && $stable(ctl_q) && $stable(de_q)));

    // R7
    drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (pix_out == pix_q));
endmodule

bind vid_ctl_demux vcd_chk #(.PW(PIX_W), .CW(CTL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .link_ok(link_ok),
    .out_en(out_en), .lock_n(lock_n), .lock_n_q(lock_n_q),
    .pix_q(pix_q), .ctl_q(ctl_q), .de_q(de_q), .pix_out(pix_out)
);

// File: tb/vid_ctl_demux_bench.sv
`timescale 1ns/1ps
module vid_ctl_demux_bench;
    localparam int PW = 18;
    localparam int CW = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          word_vld = 1'b0;
    logic [PW-1:0] word_pix = '0;
    logic [CW-1:0] word_ctl = '0;
    logic          word_de = 1'b0;
    logic          link_ok = 1'b0;
    logic          edge_rise = 1'b1;
    logic          out_en = 1'b1;

    tri1 [PW-1:0] pix_w;
    tri1 [CW-1:0] ctl_w;
    tri1          de_w;
    tri1          pclk_w;
    wire          lock_w;

    vid_ctl_demux u_vid_ctl_demux (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld),
        .word_pix(word_pix), .word_ctl(word_ctl), .word_de(word_de),
        .link_ok(link_ok), .edge_rise(edge_rise), .out_en(out_en),
        .pix_out(pix_w), .ctl_out(ctl_w), .de_out(de_w),
        .pclk_out(pclk_w), .lock_n(lock_w)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    logic [PW-1:0] m_pix = '0;
    logic [CW-1:0] m_ctl = '0;
    logic          m_de  = 1'b0;
    logic          m_lkn = 1'b1;
    logic          m_pv  = 1'b0;
    logic [PW-1:0] m_ppix = '0;
    logic [CW-1:0] m_pctl = '0;
    logic          m_pde  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " pix"}, 32'(pix_w), 32'(m_pix));
        chk({tag, " ctl"}, 32'(ctl_w), 32'(m_ctl));
        chk({tag, " de"},  32'(de_w),  32'(m_de));
        chk({tag, " lock"}, 32'(lock_w), 32'(m_lkn));
    endtask

    // one clock edge, model updated with the inputs held at that edge
    task automatic step();
        @(posedge clk);
        if (!m_lkn) begin
            if (word_vld) begin
                if (m_pv) begin
                    m_de = m_pde;
                    if (m_pde) m_pix = m_ppix;
                    else       m_ctl = m_pctl;
                end
                m_ppix = word_pix; m_pctl = word_ctl; m_pde = word_de; m_pv = 1'b1;
            end
        end else begin
            m_pv = 1'b0;
        end
        m_lkn = !link_ok;
        @(negedge clk);
    endtask

    task automatic send(input logic [PW-1:0] p, input logic [CW-1:0] c, input logic d);
        word_pix = p; word_ctl = c; word_de = d; word_vld = 1'b1;
        step();
        word_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pix", 32'(pix_w), 0);
        chk("R1 ctl", 32'(ctl_w), 0);
        chk("R1 de", 32'(de_w), 0);
        chk("R1 lock", 32'(lock_w), 1);
        rst_n = 1'b1;
        step();
        chk_all("R1 after release");
    endtask

    task automatic t_lock();
        link_ok = 1'b1;
        #1 chk("R6 lock before edge", 32'(lock_w), 1);
        step();
        chk("R6 lock after edge", 32'(lock_w), 0);
    endtask

    task automatic t_latency();
        send(18'h2A5A5, 9'h0F0, 1'b1);
        chk("R4 prime pix", 32'(pix_w), 0);
        chk("R4 prime de", 32'(de_w), 0);
        send(18'h01234, 9'h155, 1'b0);
        chk("R4 first out pix", 32'(pix_w), 32'h2A5A5);
        chk("R4 first out de", 32'(de_w), 1);
        chk_all("R4 model");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 10; i++) begin
            send(PW'(32'h3C00 + i * 32'h1111), CW'(9'h101 + i * 7), i[0]);
            chk_all(i[0] ? "R3 ctl step" : "R2 pix step");
        end
    endtask

    task automatic t_idle();
        word_vld = 1'b0;
        for (int i = 0; i < 4; i++) begin
            word_pix = PW'(i * 32'h9F9); word_ctl = CW'(i * 3); word_de = i[0];
            step();
            chk_all("R9 idle");
        end
        send(18'h15555, 9'h0AA, 1'b1);
        chk_all("R9 pending word after idle");
    endtask

    task automatic t_unlock();
        // lock drops in the same cycle as a strobe: the word is still taken
        link_ok = 1'b0;
        send(18'h00F0F, 9'h033, 1'b0);
        chk("R5 lock rises", 32'(lock_w), 1);
        chk_all("R5 same-cycle");
        for (int i = 0; i < 3; i++) begin
            send(PW'(32'h1FFF0 - i), CW'(i + 1), i[0]);
            chk_all("R5 unlocked hold");
        end
        link_ok = 1'b1;
        step();
        chk("R5 relock", 32'(lock_w), 0);
        send(18'h0BEEF, 9'h1C3, 1'b1);
        chk_all("R5 prime after relock");
        send(18'h0CAFE, 9'h03C, 1'b0);
        chk_all("R5 first out after relock");
        chk("R5 relock pix", 32'(pix_w), 32'h0BEEF);
    endtask

    task automatic t_oe();
        out_en = 1'b0;
        #1;
        chk("R7 pix float", 32'(pix_w), 32'h3FFFF);
        chk("R7 ctl float", 32'(ctl_w), 32'h1FF);
        chk("R7 de float", 32'(de_w), 1);
        chk("R7 lock driven", 32'(lock_w), 0);
        @(posedge clk); #2;
        chk("R7 pclk float", 32'(pclk_w), 1);
        @(negedge clk);
        send(18'h00777, 9'h111, 1'b1);
        send(18'h02222, 9'h0EE, 1'b0);
        send(18'h03333, 9'h099, 1'b1);
        out_en = 1'b1;
        #1 chk_all("R7 re-enabled");
    endtask

    task automatic t_edge();
        edge_rise = 1'b1;
        @(posedge clk); #2;
        chk("R8 rise mode clk high", 32'(pclk_w), 0);
        @(negedge clk); #2;
        chk("R8 rise mode clk low", 32'(pclk_w), 1);
        edge_rise = 1'b0;
        @(posedge clk); #2;
        chk("R8 fall mode clk high", 32'(pclk_w), 1);
        @(negedge clk); #2;
        chk("R8 fall mode clk low", 32'(pclk_w), 0);
        edge_rise = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_lock();
        t_latency();
        t_alternate();
        t_idle();
        t_unlock();
        t_oe();
        t_edge();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule